// File: doc/BRIEF.md
# Compare-Driven Waveform Timer

This block is an 8-bit timer/counter with a single compare channel that produces one waveform output. The counter advances on each cycle where the enable tick is high. Three modes are supported: a free-running mode, a mode that restarts the counter on a compare match, and a fast PWM mode whose period ends either at the maximum count or at the compare value. Whenever the counter matches the compare register, or wraps back to zero, the output can be set, cleared or toggled. The output can also be left alone.

Software reaches the block through a small synchronous register bus. Address 0 is the main control register, address 1 is the auxiliary control register, address 2 is the counter and address 3 is the compare register. Whenever a compare-output mode is selected, the block tells the pin multiplexer to take over the pin. It drives the pin only when the pin's direction input is high.

Top module: `tmr_wave_unit`

## Requirements
- R1: All registers reset to 0. Address 0 holds the output mode in bits 7:6, a spare 2-bit mode field in bits 5:4 and the low two waveform bits in bits 1:0, and its bits 3:2 always read 0. Address 1 holds the third waveform bit in bit 3 and reads 0 in every other bit. Addresses 2 and 3 read back the counter and the last written compare value.
- R2: The counter increments by one on each cycle with `tick` high, holds when `tick` is low, and wraps from TOP to 0. TOP is 0xFF for waveform code 000 (normal) and 011 (fast PWM).
- R3: With waveform code 010, TOP is the compare value, so the counter returns to 0 on the tick after it equals the compare value.
- R4: Outside fast PWM, a compare match applies the output mode: 01 toggles `wave_out`, 10 clears it and 11 sets it.
- R5: In fast PWM, mode 10 clears `wave_out` on match and sets it at the wrap to 0. Mode 11 sets it on match and clears it at the wrap.
- R6: In fast PWM, mode 01 leaves `wave_out` unchanged when the third waveform bit is 0. When that bit is 1 (code 111, TOP = compare value), it toggles `wave_out` on each match.
- R7: In fast PWM, with mode 10 or 11 and the compare value equal to TOP, the match action is dropped and the wrap action still applies.
- R8: In fast PWM, a written compare value takes effect only at the next wrap. In the other modes it takes effect at once.
- R9: A counter write suppresses the compare match on the following tick.
- R10: `pin_override` is 1 exactly when the output mode is nonzero. `pin_drive_en` is `pin_override` AND `pin_dir`.
- R11: Output mode 00 leaves `wave_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_dir | input | 1 | Direction bit of the pin |
| wave_out | output | 1 | Waveform output |
| pin_override | output | 1 | Waveform takes over the pin function |
| pin_drive_en | output | 1 | Output driver enable |

## Verification
Each output mode is driven through every counting mode with chosen compare values. This separates toggle, clear and set actions, and separates actions on a match from actions on a wrap. Compare values equal to TOP show whether the match or the wrap action wins. A compare value rewritten in the middle of a period shows whether the update is buffered or applied at once. A counter written to the compare value shows whether the match is suppressed. A mode-01 sweep with the third waveform bit low and then high separates an output that ignores matches from one that toggles.

// File: rtl/tmr_wave_pkg.sv
package tmr_wave_pkg;
  localparam logic [1:0] ADDR_CTRL_A = 2'd0;
  localparam logic [1:0] ADDR_CTRL_B = 2'd1;
  localparam logic [1:0] ADDR_COUNT  = 2'd2;
  localparam logic [1:0] ADDR_CMP    = 2'd3;

  typedef enum logic [1:0] {
    OUT_OFF = 2'b00,
    OUT_TGL = 2'b01,
    OUT_CLR = 2'b10,
    OUT_SET = 2'b11
  } out_mode_e;

  localparam logic [2:0] WG_NORMAL  = 3'b000;
  localparam logic [2:0] WG_CTC     = 3'b010;
  localparam logic [2:0] WG_PWM_MAX = 3'b011;
  localparam logic [2:0] WG_PWM_CMP = 3'b111;

  function automatic logic is_fast_pwm(input logic [2:0] wg);
    return wg[1:0] == 2'b11;
  endfunction

  function automatic logic top_is_cmp(input logic [2:0] wg);
    return (wg == WG_CTC) || (wg == WG_PWM_CMP);
  endfunction

  // Next level of the waveform given this tick's events
  function automatic logic wave_next(input logic pwm, input logic wg2,
                                     input logic [1:0] mode, input logic cur,
                                     input logic match, input logic wrap,
                                     input logic cmp_at_top);
    logic nxt;
    nxt = cur;
    if (mode != OUT_OFF) begin
      if (!pwm) begin
        if (match) nxt = (mode == OUT_TGL) ? ~cur : mode[0];
      end else if (mode == OUT_TGL) begin
        if (wg2 && match) nxt = ~cur;
      end else begin
        if (wrap) nxt = ~mode[0];
        else if (match && !cmp_at_top) nxt = mode[0];
      end
    end
    return nxt;
  endfunction
endpackage

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
  import tmr_wave_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [1:0]    out_mode,
  output logic [1:0]    spare_mode,
  output logic [2:0]    wg
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata[DW-1:8], wdata[2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_mode   <= '0;
      spare_mode <= '0;
      wg         <= '0;
    end else if (wr_en) begin
      if (addr == AW'(ADDR_CTRL_A)) begin
        out_mode   <= wdata[7:6];
        spare_mode <= wdata[5:4];
        wg[1:0]    <= wdata[1:0];
      end else if (addr == AW'(ADDR_CTRL_B)) begin
        wg[2] <= wdata[3];
      end
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic [DW-1:0] top,
  output logic [DW-1:0] count,
  output logic          block_match,
  output logic          wrap_evt
);
  function automatic logic [DW-1:0] count_next(input logic [DW-1:0] c,
                                               input logic [DW-1:0] t);
    return (c == t) ? '0 : c + 1'b1;
  endfunction

  assign wrap_evt = tick && (count == top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count       <= '0;
      block_match <= 1'b0;
    end else if (load) begin
      count       <= load_val;
      block_match <= 1'b1;
    end else if (tick) begin
      count       <= count_next(count, top);
      block_match <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          pwm,
  input  logic          wr_cmp,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] count,
  input  logic          block_match,
  input  logic          wrap_evt,
  output logic [DW-1:0] cmp_buf,
  output logic [DW-1:0] cmp_act,
  output logic          match_evt
);
  assign match_evt = tick && !block_match && (count == cmp_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_buf <= '0;
      cmp_act <= '0;
    end else begin
      if (wr_cmp) cmp_buf <= wdata;
      if (!pwm) begin
        if (wr_cmp) cmp_act <= wdata;
      end else if (wrap_evt) begin
        cmp_act <= cmp_buf;
      end
    end
  end
endmodule

// File: rtl/tmr_wave_gen.sv
module tmr_wave_gen
  import tmr_wave_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] out_mode,
  input  logic [2:0] wg,
  input  logic       match_evt,
  input  logic       wrap_evt,
  input  logic       cmp_at_top,
  input  logic       pin_dir,
  output logic       wave_out,
  output logic       pin_override,
  output logic       pin_drive_en
);
  assign pin_override = (out_mode != OUT_OFF);
  assign pin_drive_en = pin_override && pin_dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_out <= 1'b0;
    else wave_out <= wave_next(is_fast_pwm(wg), wg[2], out_mode, wave_out,
                               match_evt, wrap_evt, cmp_at_top);
  end
endmodule

// File: rtl/tmr_wave_unit.sv
module tmr_wave_unit
  import tmr_wave_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          pin_dir,
  output logic          wave_out,
  output logic          pin_override,
  output logic          pin_drive_en
);
  localparam logic [DW-1:0] CNT_MAX = '1;

  logic [1:0]    out_mode, spare_mode;
  logic [2:0]    wg;
  logic [DW-1:0] count, cmp_buf, cmp_act, top;
  logic          block_match, wrap_evt, match_evt, pwm, cnt_wr, cmp_wr;

  assign pwm    = is_fast_pwm(wg);
  assign top    = top_is_cmp(wg) ? cmp_act : CNT_MAX;
  assign cnt_wr = bus_wr && (bus_addr == AW'(ADDR_COUNT));
  assign cmp_wr = bus_wr && (bus_addr == AW'(ADDR_CMP));

  tmr_ctrl_regs #(.DW(DW), .AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .out_mode(out_mode), .spare_mode(spare_mode), .wg(wg)
  );

  tmr_counter #(.DW(DW)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_wr),
    .load_val(bus_wdata), .top(top), .count(count),
    .block_match(block_match), .wrap_evt(wrap_evt)
  );

  tmr_compare #(.DW(DW)) cmp_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwm(pwm), .wr_cmp(cmp_wr),
    .wdata(bus_wdata), .count(count), .block_match(block_match),
    .wrap_evt(wrap_evt), .cmp_buf(cmp_buf), .cmp_act(cmp_act),
    .match_evt(match_evt)
  );

  tmr_wave_gen gen_i (
    .clk(clk), .rst_n(rst_n), .out_mode(out_mode), .wg(wg),
    .match_evt(match_evt), .wrap_evt(wrap_evt), .cmp_at_top(cmp_act == top),
    .pin_dir(pin_dir), .wave_out(wave_out), .pin_override(pin_override),
    .pin_drive_en(pin_drive_en)
  );

  always_comb begin
    unique case (bus_addr)
      AW'(ADDR_CTRL_A): bus_rdata = DW'({out_mode, spare_mode, 2'b00, wg[1:0]});
      AW'(ADDR_CTRL_B): bus_rdata = DW'({4'b0000, wg[2], 3'b000});
      AW'(ADDR_COUNT):  bus_rdata = count;
      default:          bus_rdata = cmp_buf;
    endcase
  end
endmodule

// File: rtl/tmr_wave_unit_chk.sv
module tmr_wave_unit_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          pwm,
  input logic          cnt_wr,
  input logic [2:0]    wg,
  input logic [1:0]    out_mode,
  input logic [DW-1:0] count,
  input logic [DW-1:0] cmp_act,
  input logic          match_evt,
  input logic          wrap_evt,
  input logic          wave_out
);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(wave_out));
  // R3
  ctc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wg == 3'b010 && tick && count == cmp_act && !cnt_wr) |=> (count == '0));
  // R4
  match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm && match_evt && out_mode == 2'b10) |=> !wave_out);
  // R7
  wrap_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && out_mode[1] && wrap_evt) |=> (wave_out == !$past(out_mode[0])));
  // R8
  cmp_buffered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !wrap_evt) |=> $stable(cmp_act));
  // R11
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 2'b00) |=> $stable(wave_out));
endmodule

bind tmr_wave_unit tmr_wave_unit_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pwm(pwm), .cnt_wr(cnt_wr),
  .wg(wg), .out_mode(out_mode), .count(count), .cmp_act(cmp_act),
  .match_evt(match_evt), .wrap_evt(wrap_evt), .wave_out(wave_out)
);

// File: tb/tmr_wave_unit_tb_top.sv
module tmr_wave_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       pin_dir = 1'b0;
  logic       wave_out, pin_override, pin_drive_en;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  tmr_wave_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_dir(pin_dir), .wave_out(wave_out), .pin_override(pin_override),
    .pin_drive_en(pin_drive_en)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic step(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic chk_cnt(input string req, input logic [7:0] exp);
    logic [7:0] v;
    rd(2'd2, v);
    check(req, "count", v, exp);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); check("R1", "reset ctrl A", v, 8'h00);
    rd(2'd1, v); check("R1", "reset ctrl B", v, 8'h00);
    chk_cnt("R1", 8'h00);
    check("R1", "reset wave", {7'd0, wave_out}, 8'h00);
    check("R10", "reset override", {7'd0, pin_override}, 8'h00);
  endtask

  task automatic t_layout;
    logic [7:0] v;
    wr(2'd0, 8'hFF); rd(2'd0, v); check("R1", "ctrl A mask", v, 8'hF3);
    wr(2'd1, 8'hFF); rd(2'd1, v); check("R1", "ctrl B mask", v, 8'h08);
    wr(2'd1, 8'h00); wr(2'd0, 8'h00);
    wr(2'd3, 8'h5A); rd(2'd3, v); check("R1", "compare readback", v, 8'h5A);
  endtask

  task automatic t_normal;
    wr(2'd0, 8'h40); wr(2'd3, 8'd5); wr(2'd2, 8'd0);
    step(5);
    check("R4", "toggle before match", {7'd0, wave_out}, 8'h00);
    chk_cnt("R2", 8'd5);
    repeat (3) @(negedge clk);
    chk_cnt("R2", 8'd5); // idle hold
    step(1);
    check("R4", "toggle at match", {7'd0, wave_out}, 8'h01);
    wr(2'd0, 8'h80); wr(2'd2, 8'd0); step(6);
    check("R4", "clear at match", {7'd0, wave_out}, 8'h00);
    wr(2'd0, 8'hC0); wr(2'd2, 8'd0); step(6);
    check("R4", "set at match", {7'd0, wave_out}, 8'h01);
    wr(2'd0, 8'h00); wr(2'd2, 8'd0); step(6);
    check("R11", "mode off holds", {7'd0, wave_out}, 8'h01);
    wr(2'd2, 8'hFE); step(2);
    chk_cnt("R2", 8'h00);
  endtask

  task automatic t_override;
    pin_dir = 1'b1; #1;
    check("R10", "off override", {7'd0, pin_override}, 8'h00);
    check("R10", "off drive", {7'd0, pin_drive_en}, 8'h00);
    wr(2'd0, 8'h40); #1;
    check("R10", "on override", {7'd0, pin_override}, 8'h01);
    check("R10", "on drive", {7'd0, pin_drive_en}, 8'h01);
    pin_dir = 1'b0; #1;
    check("R10", "dir low drive", {7'd0, pin_drive_en}, 8'h00);
  endtask

  task automatic t_ctc;
    wr(2'd0, 8'h42); wr(2'd3, 8'd3); wr(2'd2, 8'd0);
    step(3);
    chk_cnt("R3", 8'd3);
    check("R3", "before restart", {7'd0, wave_out}, 8'h01);
    step(1);
    chk_cnt("R3", 8'd0);
    check("R3", "toggle at restart", {7'd0, wave_out}, 8'h00);
    step(4);
    chk_cnt("R3", 8'd0);
    check("R3", "second period", {7'd0, wave_out}, 8'h01);
  endtask

  task automatic t_block;
    wr(2'd0, 8'h40); wr(2'd3, 8'd7); wr(2'd2, 8'd7);
    step(1);
    check("R9", "match blocked", {7'd0, wave_out}, 8'h01);
    chk_cnt("R9", 8'd8);
    wr(2'd2, 8'd6); step(2);
    check("R9", "later match kept", {7'd0, wave_out}, 8'h00);
  endtask

  task automatic t_pwm;
    wr(2'd0, 8'h83); wr(2'd3, 8'h10); wr(2'd2, 8'hFE);
    step(2);
    check("R5", "set at bottom", {7'd0, wave_out}, 8'h01);
    step(16);
    check("R5", "high before match", {7'd0, wave_out}, 8'h01);
    step(1);
    check("R5", "clear at match", {7'd0, wave_out}, 8'h00);
    wr(2'd2, 8'hFE); step(2);
    wr(2'd3, 8'h20); step(17);
    check("R8", "old compare in force", {7'd0, wave_out}, 8'h00);
    wr(2'd2, 8'hFE); step(2); step(17);
    check("R8", "new compare after wrap", {7'd0, wave_out}, 8'h01);
    step(16);
    check("R8", "clear at new compare", {7'd0, wave_out}, 8'h00);
    wr(2'd0, 8'hC3); wr(2'd2, 8'hFE); step(2);
    check("R5", "inverting clear at bottom", {7'd0, wave_out}, 8'h00);
    step(32);
    check("R5", "inverting low", {7'd0, wave_out}, 8'h00);
    step(1);
    check("R5", "inverting set at match", {7'd0, wave_out}, 8'h01);
  endtask

  task automatic t_top_equal;
    wr(2'd0, 8'h83); wr(2'd3, 8'hFF); wr(2'd2, 8'hFE);
    step(2); step(256);
    check("R7", "bottom set wins", {7'd0, wave_out}, 8'h01);
    chk_cnt("R7", 8'h00);
    wr(2'd0, 8'hC3); step(256);
    check("R7", "bottom clear wins", {7'd0, wave_out}, 8'h00);
  endtask

  task automatic t_pwm_toggle;
    logic w;
    wr(2'd0, 8'h43); wr(2'd3, 8'h10); wr(2'd2, 8'hFE);
    step(2);
    w = wave_out;
    step(17);
    check("R6", "no toggle with bit clear", {7'd0, wave_out}, {7'd0, w});
    wr(2'd1, 8'h08); wr(2'd3, 8'd3); wr(2'd2, 8'h0F);
    step(2);
    check("R6", "toggle at compare top", {7'd0, wave_out}, {7'd0, ~w});
    chk_cnt("R6", 8'd0);
    step(4);
    check("R6", "short period toggle", {7'd0, wave_out}, {7'd0, w});
    chk_cnt("R6", 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_normal();
    t_override();
    t_ctc();
    t_block();
    t_pwm();
    t_top_equal();
    t_pwm_toggle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule